// File: doc/BRIEF.md
# Saturating Wiper Position Register

This block holds the live tap position of a digitally controlled potentiometer: a code from zero scale (0) to full scale (1023 at the default 10-bit width). The resistor array and the readback path both take the code from the registered output.

A caller changes the code with a one-cycle strobe that carries an opcode and a data word. The operations are:

- a direct load of a new position;
- a single-step move up or down;
- a logarithmic step that doubles the code (+6 dB) or halves it (-6 dB);
- a restore from the value held in nonvolatile storage.

Linear and logarithmic steps both clamp at the ends of the range instead of wrapping. A write-protect input freezes the code against load and step operations. Restore is still allowed while write protect is active, so that the stored setting can always be brought back. When reset is asserted, the block takes its position from the nonvolatile value, which models the restore at power-on.

Top module: `wiper_core`

## Requirements
- R1: While rst is high, code_out takes the value of nv_code at each rising clock edge.
- R2: Opcode 1 (load) with op_valid high sets code_out to op_data.
- R3: Opcode 2 (step up) adds one to the code. At the maximum code (2^W-1) the code stays unchanged.
- R4: Opcode 3 (step down) subtracts one from the code. At code 0 the code stays unchanged.
- R5: Opcode 4 (+6 dB) doubles the code. Any code whose top bit is set gives the maximum code, and 0 stays 0.
- R6: Opcode 5 (-6 dB) halves the code with a logical right shift, so an odd code rounds down.
- R7: Opcode 6 (restore) sets code_out to nv_code, whatever the state of wp_active.
- R8: While wp_active is high, opcodes 1 to 5 leave the code unchanged.
- R9: With op_valid low, or with opcode 0 (no-op) or opcode 7 (reserved), the code is unchanged.
- R10: The result of a strobe appears on code_out right after the clock edge that samples the strobe, and stays until the next change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads nv_code |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 3 | Operation select (0 to 7) |
| op_data | input | W | Position for the load operation |
| nv_code | input | W | Position held in nonvolatile storage |
| wp_active | input | 1 | Write protect; blocks opcodes 1 to 5 |
| code_out | output | W | Registered wiper position |

## Verification
Directed runs drive the step operations into both ends of the range. Step up at 1023 and step down at 0 show that the code clamps rather than wraps. Doubling is tried at 511, 512 and 0, which places the saturation boundary exactly and shows that zero is fixed. Halving 1 and 1023 shows that odd codes round down. A long random mix of all eight opcodes, with wp_active and op_valid toggled, is compared against a bench model after every strobe. This mix separates a write-protect gate that wrongly blocks restore from one that correctly lets restore through.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int OPW = 3;
  typedef enum logic [OPW-1:0] {
    OP_NOP  = 3'd0,
    OP_LOAD = 3'd1,
    OP_UP   = 3'd2,
    OP_DN   = 3'd3,
    OP_DBL  = 3'd4,
    OP_HALF = 3'd5,
    OP_RST  = 3'd6,
    OP_RSV  = 3'd7
  } wop_e;
endpackage

// File: rtl/wiper_lin_step.sv
// Single-step move with clamping at both ends of the range.
module wiper_lin_step #(
  parameter int W  = 10,
  parameter bit UP = 1'b1
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] MAXC = {W{1'b1}};
  localparam logic [W-1:0] MINC = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  generate
    if (UP) begin : g_up
      always_comb res = (cur == MAXC) ? cur : cur + ONE;
    end else begin : g_dn
      always_comb res = (cur == MINC) ? cur : cur - ONE;
    end
  endgenerate
endmodule

// File: rtl/wiper_log_step.sv
// 6 dB step: doubling saturates at full scale, halving truncates.
module wiper_log_step #(
  parameter int W  = 10,
  parameter bit UP = 1'b1
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] res
);
  localparam logic [W-1:0] MAXC = {W{1'b1}};

  generate
    if (UP) begin : g_dbl
      always_comb res = cur[W-1] ? MAXC : {cur[W-2:0], 1'b0};
    end else begin : g_half
      always_comb res = {1'b0, cur[W-1:1]};
    end
  endgenerate
endmodule

// File: rtl/wiper_next_sel.sv
// Picks the next wiper code from the candidate results, gated by write protect.
module wiper_next_sel
  import wiper_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0]   cur,
  input  logic           valid,
  input  logic [OPW-1:0] op,
  input  logic           wp,
  input  logic [W-1:0]   ld_val,
  input  logic [W-1:0]   nv_val,
  input  logic [W-1:0]   up_val,
  input  logic [W-1:0]   dn_val,
  input  logic [W-1:0]   dbl_val,
  input  logic [W-1:0]   half_val,
  output logic [W-1:0]   nxt
);
  logic guarded;

  always_comb begin
    guarded = (op == OP_LOAD) || (op == OP_UP) || (op == OP_DN) ||
              (op == OP_DBL)  || (op == OP_HALF);
    nxt = cur;
    if (valid && !(guarded && wp)) begin
      case (op)
        OP_LOAD: nxt = ld_val;
        OP_UP:   nxt = up_val;
        OP_DN:   nxt = dn_val;
        OP_DBL:  nxt = dbl_val;
        OP_HALF: nxt = half_val;
        OP_RST:  nxt = nv_val;
        default: nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/wiper_core.sv
module wiper_core
  import wiper_pkg::*;
#(
  parameter int W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [W-1:0]   op_data,
  input  logic [W-1:0]   nv_code,
  input  logic           wp_active,
  output logic [W-1:0]   code_out
);
  logic [W-1:0] pos_q;
  logic [W-1:0] pos_d;
  logic [W-1:0] lin_res [2];
  logic [W-1:0] log_res [2];

  // index 0: downward / halving, index 1: upward / doubling
  for (genvar d = 0; d < 2; d++) begin : g_dir
    wiper_lin_step #(.W(W), .UP(d == 1)) u_lin (
      .cur(pos_q), .res(lin_res[d])
    );
    wiper_log_step #(.W(W), .UP(d == 1)) u_log (
      .cur(pos_q), .res(log_res[d])
    );
  end

  wiper_next_sel #(.W(W)) u_sel (
    .cur      (pos_q),
    .valid    (op_valid),
    .op       (op_code),
    .wp       (wp_active),
    .ld_val   (op_data),
    .nv_val   (nv_code),
    .up_val   (lin_res[1]),
    .dn_val   (lin_res[0]),
    .dbl_val  (log_res[1]),
    .half_val (log_res[0]),
    .nxt      (pos_d)
  );

  always_ff @(posedge clk) begin
    if (rst) pos_q <= nv_code;
    else     pos_q <= pos_d;
  end

  assign code_out = pos_q;
endmodule

// File: rtl/wiper_core_chk.sv
module wiper_core_chk
  import wiper_pkg::*;
#(
  parameter int W = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           op_valid,
  input logic [OPW-1:0] op_code,
  input logic [W-1:0]   op_data,
  input logic [W-1:0]   nv_code,
  input logic           wp_active,
  input logic [W-1:0]   code_out
);
  localparam logic [W-1:0] MAXC = {W{1'b1}};

  logic go;
  assign go = op_valid && !wp_active;

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    go && op_code == OP_LOAD |=> code_out == $past(op_data));

  a_r3_up_clamp: assert property (@(posedge clk) disable iff (rst)
    go && op_code == OP_UP |=>
      (($past(code_out) == MAXC) ? code_out == MAXC
                                 : code_out == $past(code_out) + W'(1)));

  a_r4_dn_clamp: assert property (@(posedge clk) disable iff (rst)
    go && op_code == OP_DN |=>
      (($past(code_out) == '0) ? code_out == '0
                               : code_out == $past(code_out) - W'(1)));

  a_r5_dbl_never_falls: assert property (@(posedge clk) disable iff (rst)
    go && op_code == OP_DBL |=>
      code_out >= $past(code_out) && (code_out == MAXC || code_out[0] == 1'b0));

  a_r6_half_shrinks: assert property (@(posedge clk) disable iff (rst)
    go && op_code == OP_HALF |=>
      code_out <= $past(code_out) && code_out[W-1] == 1'b0);

  a_r7_restore: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == OP_RST |=> code_out == $past(nv_code));

  a_r8_protect: assert property (@(posedge clk) disable iff (rst)
    op_valid && wp_active && op_code != OP_RST |=> $stable(code_out));

  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !op_valid || op_code == OP_NOP || op_code == OP_RSV |=> $stable(code_out));
endmodule

bind wiper_core wiper_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .op_data(op_data), .nv_code(nv_code), .wp_active(wp_active),
  .code_out(code_out)
);

// File: tb/sim_wiper_core.sv
`timescale 1ns/1ps
module sim_wiper_core;
  localparam int W = 10;
  localparam logic [W-1:0] MAXC = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         op_valid = 1'b0;
  logic [2:0]   op_code = '0;
  logic [W-1:0] op_data = '0;
  logic [W-1:0] nv_code = '0;
  logic         wp_active = 1'b0;
  logic [W-1:0] code_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [W-1:0] exp_code;

  always #4 clk = ~clk;

  wiper_core #(.W(W)) u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_data(op_data), .nv_code(nv_code), .wp_active(wp_active),
    .code_out(code_out)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] c, input bit v,
      input logic [2:0] op, input logic [W-1:0] d, input logic [W-1:0] nv,
      input bit wp);
    if (!v) return c;
    if (op == 3'd6) return nv;
    if (wp) return c;
    case (op)
      3'd1: return d;
      3'd2: return (c == MAXC) ? c : c + 1'b1;
      3'd3: return (c == 0) ? c : c - 1'b1;
      3'd4: return (c > (MAXC >> 1)) ? MAXC : W'(c * 2);
      3'd5: return c / 2;
      default: return c;
    endcase
  endfunction

  function automatic string tag_of(input bit v, input logic [2:0] op, input bit wp);
    if (!v || op == 3'd0 || op == 3'd7) return "R9";
    if (op == 3'd6) return "R7";
    if (wp) return "R8";
    case (op)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (code_out !== exp_code) begin
      n_bad++;
      $display("FAIL %s: code_out=%0d expected=%0d", tag, code_out, exp_code);
    end
  endtask

  // drive at negedge, result registered at posedge, sampled at next negedge (R10)
  task automatic do_op(input bit v, input logic [2:0] op, input logic [W-1:0] d,
                       input logic [W-1:0] nv, input bit wp);
    op_valid = v; op_code = op; op_data = d; nv_code = nv; wp_active = wp;
    exp_code = model(exp_code, v, op, d, nv, wp);
    @(posedge clk);
    @(negedge clk);
    check(tag_of(v, op, wp));
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: code_out=%0d expected=%0d", code_out, exp_code);
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    // R1: reset restores nonvolatile value
    nv_code = 10'd341;
    repeat (2) @(posedge clk);
    @(negedge clk);
    exp_code = 10'd341;
    check("R1");
    rst = 1'b0;
    nv_code = 10'd7;
    @(negedge clk);
    check("R1 after release");
    // R2 load, R10 holding afterwards
    do_op(1, 3'd1, MAXC, 10'd7, 0);
    @(negedge clk); check("R10 hold");
    // R3 clamp at top
    do_op(1, 3'd2, 0, 0, 0);
    do_op(1, 3'd3, 0, 0, 0);
    do_op(1, 3'd2, 0, 0, 0);
    // R4 clamp at bottom
    do_op(1, 3'd1, 10'd1, 0, 0);
    do_op(1, 3'd3, 0, 0, 0);
    do_op(1, 3'd3, 0, 0, 0);
    // R5 doubling corners: 0, 511, 512
    do_op(1, 3'd4, 0, 0, 0);
    do_op(1, 3'd1, 10'd511, 0, 0);
    do_op(1, 3'd4, 0, 0, 0);
    do_op(1, 3'd1, 10'd512, 0, 0);
    do_op(1, 3'd4, 0, 0, 0);
    // R6 halving odd codes
    do_op(1, 3'd5, 0, 0, 0);
    do_op(1, 3'd1, 10'd1, 0, 0);
    do_op(1, 3'd5, 0, 0, 0);
    // R8 protect, R7 restore under protect
    do_op(1, 3'd1, 10'd100, 0, 0);
    do_op(1, 3'd1, 10'd900, 0, 1);
    do_op(1, 3'd4, 0, 0, 1);
    do_op(1, 3'd6, 0, 10'd77, 1);
    // R9 idle, reserved, no-op
    do_op(0, 3'd1, 10'd5, 0, 0);
    do_op(1, 3'd7, 10'd5, 10'd5, 0);
    do_op(1, 3'd0, 10'd5, 10'd5, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] rop;
      rop = 3'($urandom);
      do_op(($urandom % 8) != 0, rop, W'($urandom), W'($urandom),
            ($urandom % 5) == 0);
    end
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule